// File: doc/BRIEF.md
# Filtered Quadrature Position Counter with Gated Index

This block turns the two phase signals and the index signal of an incremental encoder into a signed-agnostic position count of `CNT_W` bits. The count moves by one for every edge of either phase (four counts per encoder line). Each pin is first cleaned by its own programmable glitch suppressor and then brought into the clock domain by a two-flop synchronizer. An index pulse is honoured only when the phase levels at that moment match a selected combination.

Two counting modes are offered. In index mode the count runs freely and returns to zero on a qualified index edge. In ceiling mode the index is ignored and the count is kept inside 0..ceiling, wrapping at both ends. Count resets, wraps and changes of direction set sticky status bits that are cleared by writing ones, and a single interrupt line reports any unmasked status bit.

The mode settings (filter on/off, filter length, phase swap, index gate, counting mode, ceiling) are plain inputs sampled into the block only while the enable input is low; while enabled they are frozen.

Top module: `quad_counter`

## Requirements
- R1: Phase state is the pair {A,B}. The forward sequence 00→10→11→01→00 adds one per transition, the reverse sequence subtracts one, and a free-running count wraps modulo 2^CNT_W; `dir_up` is 1 after a forward step and 0 after a reverse step.
- R2: A transition in which A and B change together leaves the count unchanged and sets `phase_err`, which stays set until the block is disabled.
- R3: With the filter on, a pin change is accepted only after it has held for `flt_len`+2 consecutive clock cycles; a shorter pulse is discarded. With the filter off, every pin change is taken on the next clock.
- R4: With `swap_ab` set the two phases exchange roles before decoding, so a motion that counts up unswapped counts down.
- R5: In index mode (`ceil_mode`=0) a rising index edge resets the count to 0 when {A,B} equals `gate_sel` (0: A low B low, 1: A low B high, 2: A high B low, 3: A high B high).
- R6: An index edge whose phase levels do not match `gate_sel`, or any index edge in ceiling mode, leaves the count unchanged.
- R7: In ceiling mode a forward step from `ceiling` gives 0 and a reverse step from 0 gives `ceiling`.
- R8: Status bit 2 is set by a reset or wrap while moving forward, bit 1 by a wrap while moving backward (or an index reset after a reverse step), bit 3 by the first step whose direction differs from the previous step; bits 0, 4 and 5 stay 0.
- R9: Status bits are sticky; a 1 on `irq_clr[i]` clears bit i, and `irq` is high exactly when some status bit is set whose `irq_mask` bit is 0.
- R10: While `en` is low the count, direction and status events do not change in response to pin activity.
- R11: Mode inputs, including `ceiling`, are taken only while `en` is low; changes made while enabled have no effect.
- R12: After reset the count is 0, the status is 0, `irq` and `phase_err` are 0 and `dir_up` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Counting enable; mode inputs load while low |
| flt_en | input | 1 | Glitch filter on |
| flt_len | input | LEN_W | Filter length N; acceptance after N+2 cycles |
| swap_ab | input | 1 | Exchange phase A and B before decoding |
| gate_sel | input | 2 | Phase levels that qualify an index edge |
| ceil_mode | input | 1 | 0: index reset mode, 1: ceiling wrap mode |
| ceiling | input | CNT_W | Upper bound of the count in ceiling mode |
| irq_mask | input | 6 | 1 suppresses the matching status bit on `irq` |
| irq_clr | input | 6 | Write-one-to-clear pulses for status bits |
| pin_a | input | 1 | Encoder phase A |
| pin_b | input | 1 | Encoder phase B |
| pin_idx | input | 1 | Encoder index |
| count | output | CNT_W | Position count |
| dir_up | output | 1 | Direction of the last step, 1 = forward |
| phase_err | output | 1 | Illegal phase transition seen |
| irq_status | output | 6 | Sticky event status |
| irq | output | 1 | Any unmasked status bit set |

## Verification
With the filter off a pin change reaches the count on the fourth rising clock edge after it is applied (filter register, two synchronizer stages, count register), and the filter adds `flt_len`+1 further edges. Index resets follow the same four-edge path and status bits appear together with the count change they describe, while `irq` follows status in the same cycle. Pins are driven on falling edges and every check waits at least eight full cycles past a stimulus (thirty in filtered runs), sampling on a falling edge, so no result is read before it is due or mixed up with the next stimulus.

// File: rtl/qcnt_pkg.sv
package qcnt_pkg;

    localparam int NIRQ          = 6;
    localparam int IRQ_WDOG      = 0;
    localparam int IRQ_RST_DN    = 1;
    localparam int IRQ_RST_UP    = 2;
    localparam int IRQ_DIR       = 3;
    localparam int IRQ_FIFO_ENT  = 4;
    localparam int IRQ_FIFO_CRIT = 5;

    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2,
        STEP_ERR  = 2'd3
    } step_e;

    typedef struct packed {
        logic       flt_en;
        logic       swap;
        logic [1:0] gate;
        logic       ceil_mode;
    } mode_t;

    // Successor of a {A,B} state in the forward direction.
    function automatic logic [1:0] fwd_state(input logic [1:0] s);
        logic [1:0] r;
        case (s)
            2'b00:   r = 2'b10;
            2'b10:   r = 2'b11;
            2'b11:   r = 2'b01;
            default: r = 2'b00;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/qcnt_filter.sv
module qcnt_filter #(
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             raw,
    input  logic             bypass,
    input  logic [LEN_W-1:0] len,
    output logic             clean
);
    localparam int CW = LEN_W + 1;

    logic [CW-1:0] hold_cnt;
    logic [CW-1:0] limit;

    assign limit = {1'b0, len} + CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            clean    <= 1'b0;
            hold_cnt <= '0;
        end else if (bypass) begin
            clean    <= raw;
            hold_cnt <= '0;
        end else if (raw != clean) begin
            if (hold_cnt == limit) begin
                clean    <= raw;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + CW'(1);
            end
        end else begin
            hold_cnt <= '0;
        end
    end

    // R3: a filtered change only passes after the full hold window
    a_r3_hold_window: assert property (@(posedge clk) disable iff (rst)
        (!$past(bypass) && clean != $past(clean)) |-> ($past(hold_cnt) == $past(limit)));

endmodule

// File: rtl/qcnt_sync.sv
module qcnt_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/qcnt_decode.sv
module qcnt_decode
    import qcnt_pkg::*;
(
    input  logic [1:0] prev,
    input  logic [1:0] cur,
    output step_e      step
);
    always_comb begin
        if (cur == prev)                 step = STEP_NONE;
        else if (cur == fwd_state(prev)) step = STEP_UP;
        else if (prev == fwd_state(cur)) step = STEP_DN;
        else                             step = STEP_ERR;
    end
endmodule

// File: rtl/quad_counter.sv
module quad_counter
    import qcnt_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int LEN_W = 21
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             flt_en,
    input  logic [LEN_W-1:0] flt_len,
    input  logic             swap_ab,
    input  logic [1:0]       gate_sel,
    input  logic             ceil_mode,
    input  logic [CNT_W-1:0] ceiling,
    input  logic [5:0]       irq_mask,
    input  logic [5:0]       irq_clr,
    input  logic             pin_a,
    input  logic             pin_b,
    input  logic             pin_idx,
    output logic [CNT_W-1:0] count,
    output logic             dir_up,
    output logic             phase_err,
    output logic [5:0]       irq_status,
    output logic             irq
);
    localparam int NPIN  = 3;
    localparam int P_A   = 0;
    localparam int P_B   = 1;
    localparam int P_IDX = 2;

    // ---------------- frozen configuration ----------------
    mode_t            mode_q;
    logic [LEN_W-1:0] len_q;
    logic [CNT_W-1:0] ceil_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
            len_q  <= '0;
            ceil_q <= '1;
        end else if (!en) begin
            mode_q <= '{flt_en: flt_en, swap: swap_ab, gate: gate_sel, ceil_mode: ceil_mode};
            len_q  <= flt_len;
            ceil_q <= ceiling;
        end
    end

    // ---------------- input conditioning ----------------
    logic [NPIN-1:0] raw_pins, flt_pins, syn_pins;
    assign raw_pins = {pin_idx, pin_b, pin_a};

    for (genvar i = 0; i < NPIN; i++) begin : g_flt
        qcnt_filter #(.LEN_W(LEN_W)) u_flt (
            .clk    (clk),
            .rst    (rst),
            .raw    (raw_pins[i]),
            .bypass (!mode_q.flt_en),
            .len    (len_q),
            .clean  (flt_pins[i])
        );
    end

    qcnt_sync #(.W(NPIN)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (flt_pins),
        .q   (syn_pins)
    );

    // ---------------- decoding ----------------
    logic [1:0] ab_phys, ab_cur, ab_prev;
    logic       idx_prev;
    step_e      step;

    assign ab_phys = {syn_pins[P_A], syn_pins[P_B]};
    assign ab_cur  = mode_q.swap ? {syn_pins[P_B], syn_pins[P_A]} : ab_phys;

    always_ff @(posedge clk) begin
        if (rst) begin
            ab_prev  <= '0;
            idx_prev <= 1'b0;
        end else begin
            ab_prev  <= ab_cur;
            idx_prev <= syn_pins[P_IDX];
        end
    end

    qcnt_decode u_dec (
        .prev (ab_prev),
        .cur  (ab_cur),
        .step (step)
    );

    logic idx_hit;
    assign idx_hit = syn_pins[P_IDX] && !idx_prev && (ab_phys == mode_q.gate)
                     && !mode_q.ceil_mode;

    // ---------------- count and events ----------------
    logic [CNT_W-1:0] count_q, count_nxt;
    logic             dir_q, dir_nxt, seen_q, seen_nxt, err_q, err_nxt;
    logic [NIRQ-1:0]  status_q, evt;

    always_comb begin
        count_nxt = count_q;
        dir_nxt   = dir_q;
        seen_nxt  = seen_q;
        err_nxt   = err_q;
        evt       = '0;
        if (!en) begin
            err_nxt = 1'b0;
        end else if (idx_hit) begin
            count_nxt = '0;
            if (dir_q) evt[IRQ_RST_UP] = 1'b1;
            else       evt[IRQ_RST_DN] = 1'b1;
        end else begin
            case (step)
                STEP_UP: begin
                    if (mode_q.ceil_mode && count_q == ceil_q) begin
                        count_nxt          = '0;
                        evt[IRQ_RST_UP]    = 1'b1;
                    end else begin
                        count_nxt = count_q + CNT_W'(1);
                    end
                end
                STEP_DN: begin
                    if (mode_q.ceil_mode && count_q == '0) begin
                        count_nxt          = ceil_q;
                        evt[IRQ_RST_DN]    = 1'b1;
                    end else begin
                        count_nxt = count_q - CNT_W'(1);
                    end
                end
                STEP_ERR: err_nxt = 1'b1;
                default:  ;
            endcase
            if (step == STEP_UP || step == STEP_DN) begin
                dir_nxt  = (step == STEP_UP);
                seen_nxt = 1'b1;
                if (seen_q && (dir_q != dir_nxt)) evt[IRQ_DIR] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q  <= '0;
            dir_q    <= 1'b1;
            seen_q   <= 1'b0;
            err_q    <= 1'b0;
            status_q <= '0;
        end else begin
            count_q  <= count_nxt;
            dir_q    <= dir_nxt;
            seen_q   <= seen_nxt;
            err_q    <= err_nxt;
            status_q <= (status_q & ~irq_clr) | evt;
        end
    end

    assign count      = count_q;
    assign dir_up     = dir_q;
    assign phase_err  = err_q;
    assign irq_status = status_q;
    assign irq        = |(status_q & ~irq_mask);

    // ---------------- assertions ----------------
    // R10: nothing moves while disabled
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(count_q));

    // R2: an illegal transition leaves the count and raises the flag
    a_r2_error_hold: assert property (@(posedge clk) disable iff (rst)
        (en && step == STEP_ERR && !idx_hit) |=> ($stable(count_q) && err_q));

    // R1: a forward step in free-running mode adds exactly one
    a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
        (en && step == STEP_UP && !idx_hit && !mode_q.ceil_mode)
        |=> (count_q == $past(count_q) + CNT_W'(1)));

    // R5: a qualified index edge zeroes the count
    a_r5_index_zero: assert property (@(posedge clk) disable iff (rst)
        (en && idx_hit) |=> (count_q == '0));

    // R7: ceiling mode keeps the count within bounds
    a_r7_ceiling_bound: assert property (@(posedge clk) disable iff (rst)
        (en && mode_q.ceil_mode && count_q <= ceil_q) |=> (count_q <= ceil_q));

    // R9: write-one-to-clear removes the addressed bits when no event can set them
    a_r9_w1c: assert property (@(posedge clk) disable iff (rst)
        (!en && |(irq_clr & status_q)) |=> ((status_q & $past(irq_clr)) == '0));

endmodule

// File: tb/test_quad_counter.sv
module test_quad_counter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        flt_en = 1'b0;
    logic [20:0] flt_len = '0;
    logic        swap_ab = 1'b0;
    logic [1:0]  gate_sel = '0;
    logic        ceil_mode = 1'b0;
    logic [31:0] ceiling = '0;
    logic [5:0]  irq_mask = '0;
    logic [5:0]  irq_clr = '0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic        pin_idx = 1'b0;
    logic [31:0] count;
    logic        dir_up, phase_err, irq;
    logic [5:0]  irq_status;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    quad_counter i_quad_counter (
        .clk(clk), .rst(rst), .en(en), .flt_en(flt_en), .flt_len(flt_len),
        .swap_ab(swap_ab), .gate_sel(gate_sel), .ceil_mode(ceil_mode),
        .ceiling(ceiling), .irq_mask(irq_mask), .irq_clr(irq_clr),
        .pin_a(pin_a), .pin_b(pin_b), .pin_idx(pin_idx),
        .count(count), .dir_up(dir_up), .phase_err(phase_err),
        .irq_status(irq_status), .irq(irq)
    );

    // {a, b, dir_up, count} after each step, free-running, filter off
    localparam logic [34:0] VECS [13] = '{
        {1'b1, 1'b0, 1'b1, 32'd1},
        {1'b1, 1'b1, 1'b1, 32'd2},
        {1'b0, 1'b1, 1'b1, 32'd3},
        {1'b0, 1'b0, 1'b1, 32'd4},
        {1'b1, 1'b0, 1'b1, 32'd5},
        {1'b0, 1'b0, 1'b0, 32'd4},
        {1'b0, 1'b1, 1'b0, 32'd3},
        {1'b1, 1'b1, 1'b0, 32'd2},
        {1'b1, 1'b0, 1'b0, 32'd1},
        {1'b0, 1'b0, 1'b0, 32'd0},
        {1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF},
        {1'b1, 1'b0, 1'b0, 32'hFFFF_FFFF},
        {1'b0, 1'b0, 1'b0, 32'hFFFF_FFFE}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; en = 1'b0; pin_a = 1'b0; pin_b = 1'b0; pin_idx = 1'b0;
        irq_clr = '0; irq_mask = '0;
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
    endtask

    task automatic setup(input logic fe, input logic [20:0] len, input logic sw,
                         input logic [1:0] g, input logic cm, input logic [31:0] ceil_v);
        @(negedge clk);
        en = 1'b0; flt_en = fe; flt_len = len; swap_ab = sw;
        gate_sel = g; ceil_mode = cm; ceiling = ceil_v;
        wait_cyc(3);
        en = 1'b1;
        wait_cyc(2);
    endtask

    task automatic drive_ab(input logic a, input logic b);
        @(negedge clk);
        pin_a = a; pin_b = b;
        wait_cyc(8);
    endtask

    task automatic pulse_idx();
        @(negedge clk);
        pin_idx = 1'b1;
        wait_cyc(3);
        pin_idx = 1'b0;
        wait_cyc(8);
    endtask

    // {A,B} after k forward steps from 00
    function automatic logic [1:0] fwd_lvl(input int k);
        case (k % 4)
            1: return 2'b10;
            2: return 2'b11;
            3: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R12: reset state
        do_reset();
        chk("R12 count", count, 32'd0);
        chk("R12 status", {26'd0, irq_status}, 32'd0);
        chk("R12 irq", {31'd0, irq}, 32'd0);
        chk("R12 phase_err", {31'd0, phase_err}, 32'd0);
        chk("R12 dir_up", {31'd0, dir_up}, 32'd1);

        // R1 / R2: vector walk, free-running, filter off
        setup(1'b0, 21'd0, 1'b0, 2'd0, 1'b0, 32'd0);
        for (int v = 0; v < 13; v++) begin
            drive_ab(VECS[v][34], VECS[v][33]);
            chk("R1 count", count, VECS[v][31:0]);
            chk("R1 dir_up", {31'd0, dir_up}, {31'd0, VECS[v][32]});
        end
        chk("R2 phase_err", {31'd0, phase_err}, 32'd1);
        // R8: only the direction-change bit was set by the walk
        chk("R8 status", {26'd0, irq_status}, 32'h08);
        // R9: irq, mask and write-one-to-clear
        chk("R9 irq unmasked", {31'd0, irq}, 32'd1);
        @(negedge clk); irq_mask = 6'h3F;
        wait_cyc(1);
        chk("R9 irq masked", {31'd0, irq}, 32'd0);
        chk("R9 status kept", {26'd0, irq_status}, 32'h08);
        @(negedge clk); irq_clr = 6'h08;
        @(negedge clk); irq_clr = 6'h00;
        wait_cyc(1);
        chk("R9 cleared", {26'd0, irq_status}, 32'h00);

        // R4: swapped phases reverse direction
        do_reset();
        setup(1'b0, 21'd0, 1'b1, 2'd0, 1'b0, 32'd0);
        drive_ab(1'b1, 1'b0);
        chk("R4 count", count, 32'hFFFF_FFFF);
        chk("R4 dir_up", {31'd0, dir_up}, 32'd0);

        // R5: index reset under each gate select
        for (int g = 0; g < 4; g++) begin
            int k;
            logic [1:0] lv;
            k = (g == 0) ? 4 : (g == 1) ? 3 : (g == 2) ? 1 : 2;
            do_reset();
            setup(1'b0, 21'd0, 1'b0, g[1:0], 1'b0, 32'd0);
            for (int s = 1; s <= k; s++) begin
                lv = fwd_lvl(s);
                drive_ab(lv[1], lv[0]);
            end
            chk("R5 pre-index count", count, k);
            pulse_idx();
            chk("R5 index reset", count, 32'd0);
            chk("R8 reset-up bit", {26'd0, irq_status}, 32'h04);
        end

        // R6: non-matching levels ignore the index
        do_reset();
        setup(1'b0, 21'd0, 1'b0, 2'd3, 1'b0, 32'd0);
        drive_ab(1'b1, 1'b0);
        pulse_idx();
        chk("R6 gate mismatch", count, 32'd1);
        chk("R6 no event", {26'd0, irq_status}, 32'd0);

        // R7 / R11 / R6 / R10: ceiling mode
        do_reset();
        setup(1'b0, 21'd0, 1'b0, 2'd3, 1'b1, 32'd2);
        @(negedge clk); ceiling = 32'd100;
        drive_ab(1'b1, 1'b0);
        drive_ab(1'b1, 1'b1);
        chk("R7 at ceiling", count, 32'd2);
        pulse_idx();
        chk("R6 index ignored in ceiling mode", count, 32'd2);
        drive_ab(1'b0, 1'b1);
        chk("R11 R7 wrap up to zero", count, 32'd0);
        chk("R8 wrap-up bit", {26'd0, irq_status}, 32'h04);
        drive_ab(1'b1, 1'b1);
        chk("R7 wrap down to ceiling", count, 32'd2);
        chk("R8 wrap-down and dir bits", {26'd0, irq_status}, 32'h0E);
        @(negedge clk); en = 1'b0;
        drive_ab(1'b0, 1'b1);
        chk("R10 disabled count", count, 32'd2);
        chk("R10 disabled status", {26'd0, irq_status}, 32'h0E);

        // R3: glitch suppression, N = 3 needs 5 stable cycles
        do_reset();
        setup(1'b1, 21'd3, 1'b0, 2'd0, 1'b0, 32'd0);
        @(negedge clk); pin_a = 1'b1;
        wait_cyc(4);
        pin_a = 1'b0;
        wait_cyc(30);
        chk("R3 short glitch ignored", count, 32'd0);
        @(negedge clk); pin_a = 1'b1;
        wait_cyc(30);
        chk("R3 held change accepted", count, 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule